// File: doc/BRIEF.md
# Multiplexed external memory bus controller

This block connects a simple internal request port to an external memory bus that carries the low address byte and the data byte on the same eight wires. A latch-enable pin marks when those wires hold the address. The high address byte has its own set of pins, and the read and write strobes are active low. Every request is sorted by its address. Addresses below the internal memory boundary `INT_TOP` go to internal memory and finish one cycle after they are accepted. Addresses at or above the boundary start a fixed three-phase external cycle with no wait states, followed by a cycle that returns completion.

A master enable `bus_en` decides who owns the pins. When it is high, the controller drives the latch-enable and both strobes and owns the high-address pins, whatever the port direction settings say. The mux-bus enables follow the access phase. When it is low, every pin passes the ordinary port value and direction through unchanged. In that mode an address at or above the boundary is unmapped: it completes without touching anything and is never folded onto internal memory. An internal access made while the bus is enabled still shows on the pins, with the address on the wires and the latch-enable high, but it never pulses a strobe.

The sequencer has seven states:
- IDLE accepts a request.
- INT_ACC serves internal memory.
- UNMAPPED completes an unmapped access.
- X_ADDR, X_LATCH and X_STROBE are the external phases.
- X_DONE returns the result.

The transitions are:
- IDLE goes to INT_ACC, UNMAPPED or X_ADDR, depending on the address class.
- X_ADDR goes to X_LATCH, X_LATCH goes to X_STROBE, and X_STROBE goes to X_DONE.
- INT_ACC, UNMAPPED and X_DONE each return to IDLE.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, and between accesses while enabled, the latch-enable pin (ctl bit 0) is low, the read strobe (ctl bit 1) and the write strobe (ctl bit 2) are high, the mux bus is released (`mux_oe` all zero), and `req_ready` is low.
- R2: A request with address below `INT_TOP` is internal. One cycle after acceptance, `req_ready` and `int_sel` are high, and `req_rdata` equals `int_rdata` for a read. This holds whether or not the bus is enabled.
- R3: While enabled, an internal access drives the latch-enable high, puts the low address byte on the mux bus and the high address byte on the high-address pins, and leaves both strobes high.
- R4: While enabled, an external access runs in this order:
  - Cycle 1 after acceptance: latch-enable high, low address byte driven on the mux bus, high byte on the high-address pins.
  - Cycle 2: latch-enable low.
  - Cycle 3: strobe phase.
  - Cycle 4: `req_ready` high.
- R5: On an external write, the mux bus carries the write data from cycle 2 through cycle 3. The write strobe is low only in cycle 3, and the read strobe stays high.
- R6: On an external read, the mux bus is released in cycles 2 and 3, and the read strobe is low only in cycle 3. The `mux_in` value present at the end of cycle 3 is returned on `req_rdata` in cycle 4.
- R7: The two strobes are never low together, and the latch-enable is low whenever a strobe is low.
- R8: The high-address pins hold one value from the address phase to the end of an external access.
- R9: While enabled, the control and high-address pins are driven (output enables all one) whatever `port_ctl_dir` and `port_hi_dir` hold.
- R10: While disabled, every pin value and enable equals the matching port data and direction. A request at or above `INT_TOP` completes one cycle after acceptance with `req_rdata` zero, `int_sel` low and no change on the pins.
- R11: `req_ready` is high for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Master enable for bus ownership of the pins |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 8 | Read data, valid with `req_ready` |
| int_sel | output | 1 | Internal memory select during an internal access |
| int_rdata | input | 8 | Read data from internal memory |
| port_mux_dout | input | 8 | Ordinary port value for the mux-bus pins |
| port_mux_dir | input | 8 | Ordinary port direction for the mux-bus pins |
| port_hi_dout | input | 8 | Ordinary port value for the high-address pins |
| port_hi_dir | input | 8 | Ordinary port direction for the high-address pins |
| port_ctl_dout | input | 3 | Ordinary port value for the control pins |
| port_ctl_dir | input | 3 | Ordinary port direction for the control pins |
| mux_out | output | 8 | Mux-bus pin value |
| mux_oe | output | 8 | Mux-bus pin output enables |
| mux_in | input | 8 | Mux-bus pin input |
| addr_hi_out | output | 8 | High-address pin value |
| addr_hi_oe | output | 8 | High-address pin output enables |
| ctl_out | output | 3 | Control pins: bit 0 latch-enable, bit 1 read strobe (active low), bit 2 write strobe (active low) |
| ctl_oe | output | 3 | Control pin output enables |

## Verification
The checker watches, on every cycle:
- that the two strobes exclude each other, and that the latch-enable is low under an active strobe;
- that an internal access never strobes, and that the bus is quiet in IDLE;
- that the strobe phase always follows the latch phase;
- that the high address holds steady through an external access;
- that completion lasts exactly one cycle;
- that pin ownership matches the enable, both when enabled and when disabled.

Only the bench scenarios can show the data path. They check that the right address and write data reach the wires in the right phase, and that the byte on the wires at the end of the strobe comes back as read data. They also check the boundary split at `INT_TOP-1` and `INT_TOP`, and that an unmapped access leaves the pins untouched and returns zero.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INT_ACC,
        ST_UNMAPPED,
        ST_X_ADDR,
        ST_X_LATCH,
        ST_X_STROBE,
        ST_X_DONE
    } xbus_state_t;

    typedef enum logic [1:0] {
        CLS_INT,
        CLS_EXT,
        CLS_NONE
    } xbus_class_t;

    localparam int CTL_LATCH = 0;
    localparam int CTL_RSTB  = 1;
    localparam int CTL_WSTB  = 2;
    localparam int CTL_W     = 3;

endpackage

// File: rtl/xbus_decode.sv
module xbus_decode
    import xbus_pkg::*;
#(
    parameter int AW      = 16,
    parameter int INT_TOP = 'h0500
) (
    input  logic [AW-1:0] addr,
    input  logic          en,
    output xbus_class_t   cls
);
    localparam logic [AW-1:0] BOUND = AW'(INT_TOP);

    // Below the boundary: internal. At or above: external only while enabled.
    always_comb begin
        if (addr < BOUND) begin
            cls = CLS_INT;
        end else if (en) begin
            cls = CLS_EXT;
        end else begin
            cls = CLS_NONE;
        end
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic           req_we,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    input  xbus_class_t    cls,
    input  logic [DW-1:0]  int_rdata,
    input  logic [DW-1:0]  mux_in,
    output xbus_state_t    state_o,
    output logic           req_ready,
    output logic [DW-1:0]  req_rdata,
    output logic           int_sel,
    output logic [DW-1:0]  bus_mux_out,
    output logic [DW-1:0]  bus_mux_oe,
    output logic [AW-DW-1:0] bus_hi,
    output logic           bus_latch,
    output logic           bus_rstb_n,
    output logic           bus_wstb_n
);
    localparam int HW = AW - DW;

    xbus_state_t   state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rcap_q;
    logic          we_q;
    logic          accept;

    assign accept = (state_q == ST_IDLE) && req_valid;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    unique case (cls)
                        CLS_INT: state_d = ST_INT_ACC;
                        CLS_EXT: state_d = ST_X_ADDR;
                        default: state_d = ST_UNMAPPED;
                    endcase
                end
            end
            ST_INT_ACC:  state_d = ST_IDLE;
            ST_UNMAPPED: state_d = ST_IDLE;
            ST_X_ADDR:   state_d = ST_X_LATCH;
            ST_X_LATCH:  state_d = ST_X_STROBE;
            ST_X_STROBE: state_d = ST_X_DONE;
            ST_X_DONE:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture and read-data capture at the end of the strobe phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            rcap_q  <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                we_q    <= req_we;
            end
            if ((state_q == ST_X_STROBE) && !we_q) begin
                rcap_q <= mux_in;
            end
        end
    end

    assign bus_hi  = addr_q[AW-1 -: HW];
    assign state_o = state_q;

    // Output logic
    always_comb begin
        bus_latch   = 1'b0;
        bus_rstb_n  = 1'b1;
        bus_wstb_n  = 1'b1;
        bus_mux_out = '0;
        bus_mux_oe  = '0;
        req_ready   = 1'b0;
        req_rdata   = '0;
        int_sel     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_INT_ACC: begin
                bus_latch   = 1'b1;
                bus_mux_out = addr_q[DW-1:0];
                bus_mux_oe  = '1;
                int_sel     = 1'b1;
                req_ready   = 1'b1;
                req_rdata   = we_q ? '0 : int_rdata;
            end
            ST_UNMAPPED: begin
                req_ready = 1'b1;
            end
            ST_X_ADDR: begin
                bus_latch   = 1'b1;
                bus_mux_out = addr_q[DW-1:0];
                bus_mux_oe  = '1;
            end
            ST_X_LATCH: begin
                bus_mux_out = we_q ? wdata_q : '0;
                bus_mux_oe  = {DW{we_q}};
            end
            ST_X_STROBE: begin
                bus_mux_out = we_q ? wdata_q : '0;
                bus_mux_oe  = {DW{we_q}};
                bus_rstb_n  = we_q;
                bus_wstb_n  = !we_q;
            end
            ST_X_DONE: begin
                req_ready = 1'b1;
                req_rdata = we_q ? '0 : rcap_q;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/xbus_pinmux.sv
module xbus_pinmux #(
    parameter int W = 8
) (
    input  logic         en,
    input  logic [W-1:0] bus_val,
    input  logic [W-1:0] bus_oe,
    input  logic [W-1:0] port_val,
    input  logic [W-1:0] port_dir,
    output logic [W-1:0] pin_val,
    output logic [W-1:0] pin_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        assign pin_val[i] = en ? bus_val[i] : port_val[i];
        assign pin_oe[i]  = en ? bus_oe[i]  : port_dir[i];
    end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int INT_TOP = 'h0500
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               req_valid,
    input  logic               req_we,
    input  logic [AW-1:0]      req_addr,
    input  logic [DW-1:0]      req_wdata,
    output logic               req_ready,
    output logic [DW-1:0]      req_rdata,
    output logic               int_sel,
    input  logic [DW-1:0]      int_rdata,
    input  logic [DW-1:0]      port_mux_dout,
    input  logic [DW-1:0]      port_mux_dir,
    input  logic [AW-DW-1:0]   port_hi_dout,
    input  logic [AW-DW-1:0]   port_hi_dir,
    input  logic [2:0]         port_ctl_dout,
    input  logic [2:0]         port_ctl_dir,
    output logic [DW-1:0]      mux_out,
    output logic [DW-1:0]      mux_oe,
    input  logic [DW-1:0]      mux_in,
    output logic [AW-DW-1:0]   addr_hi_out,
    output logic [AW-DW-1:0]   addr_hi_oe,
    output logic [2:0]         ctl_out,
    output logic [2:0]         ctl_oe
);
    localparam int HW = AW - DW;

    xbus_class_t     cls;
    xbus_state_t     state;
    logic [DW-1:0]   bus_mux_out;
    logic [DW-1:0]   bus_mux_oe;
    logic [HW-1:0]   bus_hi;
    logic            bus_latch;
    logic            bus_rstb_n;
    logic            bus_wstb_n;
    logic [CTL_W-1:0] bus_ctl;

    xbus_decode #(.AW(AW), .INT_TOP(INT_TOP)) u_decode (
        .addr (req_addr),
        .en   (bus_en),
        .cls  (cls)
    );

    xbus_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_we      (req_we),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .cls         (cls),
        .int_rdata   (int_rdata),
        .mux_in      (mux_in),
        .state_o     (state),
        .req_ready   (req_ready),
        .req_rdata   (req_rdata),
        .int_sel     (int_sel),
        .bus_mux_out (bus_mux_out),
        .bus_mux_oe  (bus_mux_oe),
        .bus_hi      (bus_hi),
        .bus_latch   (bus_latch),
        .bus_rstb_n  (bus_rstb_n),
        .bus_wstb_n  (bus_wstb_n)
    );

    always_comb begin
        bus_ctl            = '0;
        bus_ctl[CTL_LATCH] = bus_latch;
        bus_ctl[CTL_RSTB]  = bus_rstb_n;
        bus_ctl[CTL_WSTB]  = bus_wstb_n;
    end

    xbus_pinmux #(.W(DW)) u_mux_pins (
        .en       (bus_en),
        .bus_val  (bus_mux_out),
        .bus_oe   (bus_mux_oe),
        .port_val (port_mux_dout),
        .port_dir (port_mux_dir),
        .pin_val  (mux_out),
        .pin_oe   (mux_oe)
    );

    xbus_pinmux #(.W(HW)) u_hi_pins (
        .en       (bus_en),
        .bus_val  (bus_hi),
        .bus_oe   ({HW{1'b1}}),
        .port_val (port_hi_dout),
        .port_dir (port_hi_dir),
        .pin_val  (addr_hi_out),
        .pin_oe   (addr_hi_oe)
    );

    xbus_pinmux #(.W(CTL_W)) u_ctl_pins (
        .en       (bus_en),
        .bus_val  (bus_ctl),
        .bus_oe   ({CTL_W{1'b1}}),
        .port_val (port_ctl_dout),
        .port_dir (port_ctl_dir),
        .pin_val  (ctl_out),
        .pin_oe   (ctl_oe)
    );
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk
    import xbus_pkg::*;
#(
    parameter int DW = 8,
    parameter int HW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_en,
    input xbus_state_t   state,
    input logic          req_ready,
    input logic          int_sel,
    input logic          bus_latch,
    input logic          bus_rstb_n,
    input logic          bus_wstb_n,
    input logic [DW-1:0] bus_mux_oe,
    input logic [HW-1:0] bus_hi,
    input logic [DW-1:0] mux_oe,
    input logic [DW-1:0] port_mux_dir,
    input logic [HW-1:0] addr_hi_oe,
    input logic [2:0]    ctl_oe,
    input logic [2:0]    port_ctl_dir
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rstb_n && !bus_wstb_n)); // R7

    AST_LATCH_LOW_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rstb_n || !bus_wstb_n) |-> !bus_latch); // R7

    AST_INT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        int_sel |-> (bus_rstb_n && bus_wstb_n)); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!bus_latch && bus_rstb_n && bus_wstb_n && bus_mux_oe == '0 && !req_ready)); // R1

    AST_STROBE_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rstb_n || !bus_wstb_n) |-> ($past(state) == ST_X_LATCH)); // R4

    AST_HI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_X_LATCH || state == ST_X_STROBE || state == ST_X_DONE) |-> $stable(bus_hi)); // R8

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready); // R11

    AST_PIN_TAKEOVER: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |-> (ctl_oe == 3'b111 && addr_hi_oe == '1)); // R9

    AST_PIN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> (ctl_oe == port_ctl_dir && mux_oe == port_mux_dir)); // R10
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.DW(DW), .HW(AW-DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_en       (bus_en),
    .state        (state),
    .req_ready    (req_ready),
    .int_sel      (int_sel),
    .bus_latch    (bus_latch),
    .bus_rstb_n   (bus_rstb_n),
    .bus_wstb_n   (bus_wstb_n),
    .bus_mux_oe   (bus_mux_oe),
    .bus_hi       (bus_hi),
    .mux_oe       (mux_oe),
    .port_mux_dir (port_mux_dir),
    .addr_hi_oe   (addr_hi_oe),
    .ctl_oe       (ctl_oe),
    .port_ctl_dir (port_ctl_dir)
);

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;
    localparam int          INT_TOP = 'h0500;
    localparam logic [15:0] BOUND   = 16'h0500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic [7:0]  req_rdata;
    logic        int_sel;
    logic [7:0]  int_rdata = '0;
    logic [7:0]  port_mux_dout = '0, port_mux_dir = '0;
    logic [7:0]  port_hi_dout = '0, port_hi_dir = '0;
    logic [2:0]  port_ctl_dout = '0, port_ctl_dir = '0;
    logic [7:0]  mux_out, mux_oe;
    logic [7:0]  mux_in = '0;
    logic [7:0]  addr_hi_out, addr_hi_oe;
    logic [2:0]  ctl_out, ctl_oe;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    xbus_ctrl #(.AW(16), .DW(8), .INT_TOP(INT_TOP)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .req_rdata(req_rdata), .int_sel(int_sel), .int_rdata(int_rdata),
        .port_mux_dout(port_mux_dout), .port_mux_dir(port_mux_dir),
        .port_hi_dout(port_hi_dout), .port_hi_dir(port_hi_dir),
        .port_ctl_dout(port_ctl_dout), .port_ctl_dir(port_ctl_dir),
        .mux_out(mux_out), .mux_oe(mux_oe), .mux_in(mux_in),
        .addr_hi_out(addr_hi_out), .addr_hi_oe(addr_hi_oe),
        .ctl_out(ctl_out), .ctl_oe(ctl_oe)
    );

    function automatic logic [7:0] ext_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic logic [7:0] int_byte(input logic [15:0] a);
        return a[7:0] + 8'h3C;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic en, input logic we, input logic [15:0] a, input logic [7:0] wd);
        int  cyc;
        bit  done;
        bit  is_int;
        @(negedge clk);
        bus_en        = en;
        req_valid     = 1'b1;
        req_we        = we;
        req_addr      = a;
        req_wdata     = wd;
        int_rdata     = int_byte(a);
        port_mux_dout = 8'($urandom);
        port_mux_dir  = 8'($urandom);
        port_hi_dout  = 8'($urandom);
        port_hi_dir   = 8'($urandom);
        port_ctl_dout = 3'($urandom);
        port_ctl_dir  = 3'($urandom);
        is_int = (a < BOUND);
        cyc = 0;
        done = 1'b0;
        while (!done) begin
            @(negedge clk);
            cyc++;
            if (!en) begin
                chk("R10", "mux pins follow port", {mux_oe, mux_out}, {port_mux_dir, port_mux_dout});
                chk("R10", "ctl pins follow port", {ctl_oe, ctl_out}, {port_ctl_dir, port_ctl_dout});
                chk("R10", "hi pins follow port", {addr_hi_oe, addr_hi_out}, {port_hi_dir, port_hi_dout});
            end else begin
                chk("R9", "ctl and hi driven", {ctl_oe, addr_hi_oe}, {3'b111, 8'hFF});
            end
            if (is_int) begin
                chk("R2", "internal ready", req_ready, 1);
                chk("R2", "internal select", int_sel, 1);
                if (!we) chk("R2", "internal rdata", req_rdata, int_byte(a));
                if (en) begin
                    chk("R3", "internal latch and addr", {ctl_out, mux_oe, mux_out, addr_hi_out},
                        {3'b111, 8'hFF, a[7:0], a[15:8]});
                end
                done = 1'b1;
            end else if (!en) begin
                chk("R10", "unmapped ready", req_ready, 1);
                chk("R10", "unmapped rdata and select", {req_rdata, int_sel}, 9'h000);
                done = 1'b1;
            end else begin
                unique case (cyc)
                    1: begin
                        chk("R4", "addr phase pins", {ctl_out, mux_oe, mux_out, addr_hi_out},
                            {3'b111, 8'hFF, a[7:0], a[15:8]});
                        chk("R4", "no ready in addr phase", req_ready, 0);
                    end
                    2: begin
                        chk("R4", "latch phase ctl", ctl_out, 3'b110);
                        if (we) chk("R5", "write data on bus", {mux_oe, mux_out}, {8'hFF, wd});
                        else    chk("R6", "bus released for read", mux_oe, 8'h00);
                    end
                    3: begin
                        if (we) begin
                            chk("R5", "write strobe phase", ctl_out, 3'b010);
                            chk("R5", "write data held", {mux_oe, mux_out}, {8'hFF, wd});
                        end else begin
                            chk("R6", "read strobe phase", {ctl_out, mux_oe}, {3'b100, 8'h00});
                            mux_in = ext_byte(a);
                        end
                        chk("R7", "one strobe low", 32'(ctl_out[1] | ctl_out[2]), 1);
                        chk("R8", "hi addr steady", addr_hi_out, a[15:8]);
                    end
                    4: begin
                        chk("R4", "ready after strobe", req_ready, 1);
                        chk("R8", "hi addr steady at end", addr_hi_out, a[15:8]);
                        if (!we) chk("R6", "read data returned", req_rdata, ext_byte(a));
                        done = 1'b1;
                    end
                    default: begin
                        chk("R4", "access overran", cyc, 4);
                        done = 1'b1;
                    end
                endcase
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        mux_in = 8'h00;
        chk("R11", "ready drops", req_ready, 0);
        if (en) chk("R1", "idle pins", {ctl_out, mux_oe}, {3'b110, 8'h00});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog: actual %0d cycles expected completion", 200000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state while enabled
        chk("R1", "reset ctl pins", ctl_out, 3'b110);
        chk("R1", "reset bus released", mux_oe, 8'h00);
        chk("R1", "reset ready low", req_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after reset", {ctl_out, mux_oe, req_ready}, {3'b110, 8'h00, 1'b0});

        // Directed corners around the boundary
        access(1'b1, 1'b0, BOUND - 16'd1, 8'h00);
        access(1'b1, 1'b0, BOUND, 8'h00);
        access(1'b1, 1'b1, BOUND, 8'h5A);
        access(1'b1, 1'b0, 16'hFFFF, 8'h00);
        access(1'b1, 1'b1, 16'h0000, 8'h77);
        access(1'b0, 1'b0, BOUND, 8'h00);
        access(1'b0, 1'b1, 16'hFFFF, 8'hC3);
        access(1'b0, 1'b0, 16'h0010, 8'h00);

        // Constrained random mix
        for (int i = 0; i < 300; i++) begin
            logic [15:0] a;
            logic        en;
            en = ($urandom % 5) != 0;
            if ($urandom % 3 == 0) a = 16'($urandom % INT_TOP);
            else                   a = BOUND + 16'($urandom % (32'h10000 - INT_TOP));
            access(en, 1'($urandom), a, 8'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule